// File: doc/BRIEF.md
# Clock-Pair Enable Controller with Serial Block Access

This block is the control side of a differential clock fanout device. A buffered reference clock is copied onto six true/complement output pairs. Each pair can be switched off through a small bank of nine control bytes. The bank is reached over a two-wire serial bus (I2C/SMBus style, standard-mode rate). The system clock oversamples the bus.

Writes are block writes. After the slave address, the host sends two bytes that the slave acknowledges and throws away. Every later byte fills the bank from byte 0 upward. Reads are block reads. The first byte returned is a fixed byte count, and the bank contents follow from byte 0 upward. Neither direction has any register addressing.

Two of the bytes carry the pair enables. A disabled pair parks with its true output low and its complement output high. Enable changes are moved into the reference clock domain and applied only while that clock is low.

Top module: `clkfan_smb_ctrl`

## Requirements
- R1: The slave answers only to the 7-bit address 1101001, that is 0xD2 for a write and 0xD3 for a read. Any other address byte gets no acknowledge, and the slave ignores the bus until the next START.
- R2: In a write, the two bytes that follow the address are acknowledged and discarded. The third byte and each later byte go to bank bytes 0, 1, 2 and so on, in that order.
- R3: In a read, the first byte returned is the byte count 0x09. The bank bytes follow in order from byte 0 upward.
- R4: After reset, byte 6 is 0x8F, byte 7 is 0xFF and the other bytes are 0x00, so all six pairs are enabled.
- R5: The slave acknowledges every byte of a write by pulling SDA low, and it only starts driving SDA while SCL is low. In a read, a NACK from the master ends the transfer: the slave releases SDA and stays off the bus until a START.
- R6: Byte 7 holds the enables for pairs 0, 1 and 2 in bits 0, 2 and 4. Byte 6 holds the enables for pairs 3, 4 and 5 in bits 0, 1 and 2. A bit value of 1 enables the pair.
- R7: An enabled pair drives true = reference clock and complement = inverted reference clock. A disabled pair drives true = 0 and complement = 1.
- R8: Enable changes reach the outputs only on a falling edge of the reference clock, so no high pulse on a true output is ever cut short.
- R9: Reserved bits, and bytes 0 to 5 and 8, hold whatever was written and read back unchanged.
- R10: Written bytes past byte 8 are acknowledged and dropped. Read bytes past byte 8 return 0xFF.
- R11: A START at any point abandons the current transfer, including a partly shifted byte, and begins a new address phase. A STOP releases SDA and returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10 times the bus bit rate |
| rst | input | 1 | Synchronous active-high reset, seen by both clock domains |
| scl_i | input | 1 | Serial clock line as received |
| sda_i | input | 1 | Serial data line as received |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain driver enable) |
| ref_clk_i | input | 1 | Buffered reference clock to be fanned out |
| pair_t_o | output | 6 | True outputs of the six pairs |
| pair_c_o | output | 6 | Complement outputs of the six pairs |

## Verification
The bench sends a write whose byte-count byte (0x04) does not match the number of data bytes sent. It then checks that the command and count bytes never show up in byte 0 and that the bank fills from byte 0. A design that stored the header bytes, or trusted the count, would read back shifted or truncated data. Further tests abandon a write midway through a byte with a repeated START, and end a read with a NACK followed by extra clocks. A slave that kept a partial byte, or kept driving after the NACK, would show a corrupted byte 1 or a low bit where the line should float high. While enables are toggled, a monitor samples every reference high phase twice. An enable applied outside the low phase would show up as a true output whose value differs between the two samples.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

  localparam int NUM_PAIRS = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } bus_state_t;

  // bank byte that carries the enable of pair p
  function automatic int pair_byte(input int p);
    return (p < 3) ? 7 : 6;
  endfunction

  // bit position of the enable of pair p inside its byte
  function automatic int pair_bit(input int p);
    return (p < 3) ? 2 * p : p - 3;
  endfunction

  // value a bank byte takes at reset
  function automatic logic [7:0] reg_reset(input int idx);
    case (idx)
      6:       return 8'h8F;
      7:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/clkfan_bus_sync.sv
module clkfan_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_ff;
  logic [SYNC_STAGES-1:0] sda_ff;
  logic                   scl_q;
  logic                   sda_q;
  logic                   scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data edge while the clock stays high marks a bus condition
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/clkfan_smb_slave.sv
module clkfan_smb_slave
  import clkfan_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h69,
  parameter int         NUM_REGS   = 9,
  parameter logic [7:0] BYTE_COUNT = 8'h09,
  parameter int         PW         = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [PW-1:0] rd_addr,
  output logic          wr_stb,
  output logic [PW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);

  localparam logic [PW-1:0] WR_FIRST = PW'(2);
  localparam logic [PW-1:0] WR_END   = PW'(NUM_REGS + 2);
  localparam logic [PW-1:0] RD_LAST  = PW'(NUM_REGS);

  bus_state_t    state;
  logic [3:0]    bit_cnt;
  logic [7:0]    shreg;
  logic [7:0]    tx;
  logic          rw;
  logic          mack;
  logic [PW-1:0] wr_pos;
  logic [PW-1:0] rd_pos;
  logic [7:0]    next_byte;

  // position 0 of a read is the count, then the bank, then filler
  assign rd_addr = rd_pos - PW'(1);

  always_comb begin
    if (rd_pos == '0)
      next_byte = BYTE_COUNT;
    else if (rd_pos <= RD_LAST)
      next_byte = rd_data;
    else
      next_byte = 8'hFF;
  end

  always_ff @(posedge clk) begin
    wr_stb <= 1'b0;
    if (rst) begin
      state   <= ST_IDLE;
      sda_oe  <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      wr_pos  <= '0;
      rd_pos  <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (start_det) begin
      state   <= ST_ADDR;
      sda_oe  <= 1'b0;
      bit_cnt <= '0;
      wr_pos  <= '0;
      rd_pos  <= '0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WR_BYTE: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            bit_cnt <= '0;
            if (state == ST_ADDR) begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rw     <= shreg[0];
                state  <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sda_oe <= 1'b1;
              state  <= ST_WR_ACK;
              if (wr_pos >= WR_FIRST && wr_pos < WR_END) begin
                wr_stb  <= 1'b1;
                wr_addr <= wr_pos - WR_FIRST;
                wr_data <= shreg;
              end
              if (wr_pos != '1) wr_pos <= wr_pos + PW'(1);
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw) begin
              tx     <= next_byte;
              sda_oe <= ~next_byte[7];
              rd_pos <= rd_pos + PW'(1);
              state  <= ST_RD_BYTE;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WR_BYTE;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_RD_ACK;
            end else begin
              tx      <= {tx[6:0], 1'b0};
              sda_oe  <= ~tx[6];
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              tx     <= next_byte;
              sda_oe <= ~next_byte[7];
              if (rd_pos != '1) rd_pos <= rd_pos + PW'(1);
              state  <= ST_RD_BYTE;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: begin
          sda_oe <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/clkfan_regbank.sv
module clkfan_regbank
  import clkfan_pkg::*;
#(
  parameter int NUM_REGS = 9,
  parameter int PW       = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_stb,
  input  logic [PW-1:0]        wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [PW-1:0]        rd_addr,
  output logic [7:0]           rd_data,
  output logic [NUM_PAIRS-1:0] pair_en
);

  logic [7:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_REGS; k++) mem[k] <= reg_reset(k);
    end else if (wr_stb) begin
      for (int k = 0; k < NUM_REGS; k++)
        if (wr_addr == PW'(k)) mem[k] <= wr_data;
    end
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int k = 0; k < NUM_REGS; k++)
      if (rd_addr == PW'(k)) rd_data = mem[k];
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_en
    localparam int SRC_BYTE = pair_byte(p);
    localparam int SRC_BIT  = pair_bit(p);
    assign pair_en[p] = mem[SRC_BYTE][SRC_BIT];
  end

endmodule

// File: rtl/clkfan_pair_gate.sv
module clkfan_pair_gate #(
  parameter int NUM_PAIRS = 6
) (
  input  logic                 ref_clk,
  input  logic                 rst,
  input  logic [NUM_PAIRS-1:0] en_i,
  output logic [NUM_PAIRS-1:0] true_o,
  output logic [NUM_PAIRS-1:0] comp_o
);

  logic [NUM_PAIRS-1:0] en_meta;
  logic [NUM_PAIRS-1:0] en_sync;
  logic [NUM_PAIRS-1:0] en_live;

  // every stage moves on the falling edge, so the live enable
  // only changes while the reference is low
  always_ff @(negedge ref_clk) begin
    if (rst) begin
      en_meta <= '1;
      en_sync <= '1;
      en_live <= '1;
    end else begin
      en_meta <= en_i;
      en_sync <= en_meta;
      en_live <= en_sync;
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign true_o[p] = ref_clk & en_live[p];
    assign comp_o[p] = ~(ref_clk & en_live[p]);
  end

endmodule

// File: rtl/clkfan_smb_ctrl.sv
module clkfan_smb_ctrl
  import clkfan_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 9,
  parameter logic [7:0] BYTE_COUNT  = 8'h09,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic                 ref_clk_i,
  output logic [NUM_PAIRS-1:0] pair_t_o,
  output logic [NUM_PAIRS-1:0] pair_c_o
);

  localparam int PW = $clog2(NUM_REGS + 3) + 1;

  logic                 sda_s;
  logic                 scl_rise;
  logic                 scl_fall;
  logic                 start_det;
  logic                 stop_det;
  logic [7:0]           rd_data;
  logic [PW-1:0]        rd_addr;
  logic                 wr_stb;
  logic [PW-1:0]        wr_addr;
  logic [7:0]           wr_data;
  logic [NUM_PAIRS-1:0] pair_en;

  clkfan_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  clkfan_smb_slave #(
    .DEV_ADDR   (DEV_ADDR),
    .NUM_REGS   (NUM_REGS),
    .BYTE_COUNT (BYTE_COUNT),
    .PW         (PW)
  ) u_slave (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe_o)
  );

  clkfan_regbank #(.NUM_REGS(NUM_REGS), .PW(PW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .pair_en (pair_en)
  );

  clkfan_pair_gate #(.NUM_PAIRS(NUM_PAIRS)) u_gate (
    .ref_clk (ref_clk_i),
    .rst     (rst),
    .en_i    (pair_en),
    .true_o  (pair_t_o),
    .comp_o  (pair_c_o)
  );

endmodule

// File: rtl/clkfan_smb_ctrl_chk.sv
module clkfan_smb_ctrl_chk #(
  parameter int NUM_REGS = 9,
  parameter int PW       = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          start_det,
  input logic          stop_det,
  input logic          wr_stb,
  input logic [PW-1:0] wr_addr,
  input logic [2:0]    wr_even3,
  input logic [2:0]    wr_low3,
  input logic [5:0]    pair_en
);

  // R11
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R5
  drive_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  // R10
  wr_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (wr_addr < PW'(NUM_REGS)));

  // R6
  map_byte7_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_addr == PW'(7)) |=> (pair_en[2:0] == $past(wr_even3)));

  // R6
  map_byte6_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_addr == PW'(6)) |=> (pair_en[5:3] == $past(wr_low3)));

  // R4
  reset_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pair_en == 6'h3F));

endmodule

bind clkfan_smb_ctrl clkfan_smb_ctrl_chk #(.NUM_REGS(NUM_REGS), .PW(PW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe_o),
  .start_det (start_det),
  .stop_det  (stop_det),
  .wr_stb    (wr_stb),
  .wr_addr   (wr_addr),
  .wr_even3  ({wr_data[4], wr_data[2], wr_data[0]}),
  .wr_low3   (wr_data[2:0]),
  .pair_en   (pair_en)
);

// File: tb/clkfan_smb_ctrl_tb.sv
`timescale 1ns/1ps
module clkfan_smb_ctrl_tb;

  localparam int TQ = 20;  // quarter bit in system clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_clk = 1'b0;
  logic       scl = 1'b1;
  logic       m_low = 1'b0;
  logic       sda_oe;
  logic [5:0] pt, pc;
  wire        sda_line;
  int         n_chk = 0;
  int         n_fail = 0;
  int         glitch = 0;
  bit         done = 1'b0;
  logic [7:0] exp_q [16];

  assign sda_line = ~(m_low | sda_oe);

  always #10 clk = ~clk;
  always #100 ref_clk = ~ref_clk;

  clkfan_smb_ctrl u_dut (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .sda_oe_o  (sda_oe),
    .ref_clk_i (ref_clk),
    .pair_t_o  (pt),
    .pair_c_o  (pc)
  );

  // R8: a true output must hold one value through each high phase
  always @(posedge ref_clk) begin
    logic [5:0] a;
    #25 a = pt;
    #50 if (!rst && a !== pt) glitch++;
  end

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; tick(TQ);
    scl = 1'b1;   tick(TQ);
    m_low = 1'b1; tick(TQ);
    scl = 1'b0;   tick(TQ);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(TQ);
    scl = 1'b1;   tick(TQ);
    m_low = 1'b0; tick(TQ);
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b; tick(TQ);
    scl = 1'b1; tick(2 * TQ);
    scl = 1'b0; tick(TQ);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_low = 1'b0; tick(TQ);
    scl = 1'b1;   tick(TQ);
    ack = ~sda_line; tick(TQ);
    scl = 1'b0;   tick(TQ);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_low = 1'b0;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(TQ); scl = 1'b1;
      tick(TQ); b = {b[6:0], sda_line};
      tick(TQ); scl = 1'b0;
      tick(TQ);
    end
    m_low = give_ack; tick(TQ);
    scl = 1'b1; tick(2 * TQ);
    scl = 1'b0; tick(TQ);
    m_low = 1'b0;
  endtask

  // reads n bytes and compares them with exp_q
  task automatic read_block(input string req, input int n);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, ack);
    chk("R1", "read address ack", {7'b0, ack}, 8'h01);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(req, $sformatf("read byte %0d", i), b, exp_q[i]);
    end
    bus_stop();
  endtask

  task automatic check_pairs(input string req, input logic [5:0] en);
    repeat (6) @(posedge ref_clk);
    #55;
    chk(req, "true outputs, reference high", {2'b0, pt}, {2'b0, en});
    chk(req, "comp outputs, reference high", {2'b0, pc}, {2'b0, ~en});
    @(negedge ref_clk);
    #55;
    chk(req, "true outputs, reference low", {2'b0, pt}, 8'h00);
    chk(req, "comp outputs, reference low", {2'b0, pc}, 8'h3F);
  endtask

  // R4 R3 R10: defaults after reset
  task automatic t_reset_state();
    chk("R4", "sda released in reset", {7'b0, sda_oe}, 8'h00);
    check_pairs("R4", 6'h3F);
    exp_q[0] = 8'h09;
    for (int i = 1; i <= 9; i++) exp_q[i] = 8'h00;
    exp_q[7] = 8'h8F;
    exp_q[8] = 8'hFF;
    exp_q[10] = 8'hFF;
    read_block("R4", 11);
  endtask

  // R1: foreign addresses get no ack and the rest is ignored
  task automatic t_wrong_address();
    logic ack;
    bus_start();
    send_byte(8'hD0, ack);
    chk("R1", "ack for address 0x68", {7'b0, ack}, 8'h00);
    send_byte(8'h00, ack);
    chk("R1", "ack after foreign address", {7'b0, ack}, 8'h00);
    bus_stop();
    bus_start();
    send_byte(8'hA5, ack);
    chk("R1", "ack for address 0x52", {7'b0, ack}, 8'h00);
    bus_stop();
  endtask

  // R2 R5 R6 R7 R9 R10: block write with a misleading count byte
  task automatic t_block_write();
    logic ack;
    logic [7:0] data [11] = '{8'h3C, 8'hA5, 8'h01, 8'h80, 8'h7E, 8'h55,
                              8'hFA, 8'hAB, 8'hC9, 8'h12, 8'h34};
    bus_start();
    send_byte(8'hD2, ack);
    chk("R1", "write address ack", {7'b0, ack}, 8'h01);
    send_byte(8'h5A, ack);
    chk("R2", "command byte ack", {7'b0, ack}, 8'h01);
    send_byte(8'h04, ack);
    chk("R2", "count byte ack", {7'b0, ack}, 8'h01);
    for (int i = 0; i < 11; i++) begin
      send_byte(data[i], ack);
      chk(i > 8 ? "R10" : "R5", $sformatf("data byte %0d ack", i),
          {7'b0, ack}, 8'h01);
    end
    bus_stop();
    exp_q[0] = 8'h09;
    for (int i = 0; i < 9; i++) exp_q[i + 1] = data[i];
    exp_q[10] = 8'hFF;
    exp_q[11] = 8'hFF;
    read_block("R9", 12);
    // byte6 0xFA -> pairs 3,5 off, 4 on; byte7 0xAB -> pair 0 on, 1,2 off
    check_pairs("R6", 6'b010001);
    check_pairs("R7", 6'b010001);
  endtask

  // R5: master NACK ends the read, slave leaves the line floating
  task automatic t_nack_read();
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, ack);
    recv_byte(1'b0, b);
    chk("R3", "count byte first", b, 8'h09);
    recv_byte(1'b0, b);
    chk("R5", "line after master NACK", b, 8'hFF);
    bus_stop();
  endtask

  // R11: repeated START in the middle of a byte
  task automatic t_restart();
    logic ack;
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h00, ack);
    send_byte(8'h00, ack);
    send_byte(8'h66, ack);
    chk("R2", "byte 0 ack", {7'b0, ack}, 8'h01);
    send_bit(1'b0);
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b0);
    exp_q[0] = 8'h09;
    exp_q[1] = 8'h66;
    exp_q[2] = 8'hA5;
    read_block("R11", 3);
  endtask

  // R8: toggle enables repeatedly while the glitch monitor runs
  task automatic t_toggle();
    logic ack;
    logic [7:0] b6 [3] = '{8'h8F, 8'h00, 8'h8F};
    logic [7:0] b7 [3] = '{8'h00, 8'hFF, 8'h15};
    for (int r = 0; r < 3; r++) begin
      bus_start();
      send_byte(8'hD2, ack);
      send_byte(8'h00, ack);
      send_byte(8'h00, ack);
      for (int i = 0; i < 6; i++) send_byte(8'h00, ack);
      send_byte(b6[r], ack);
      send_byte(b7[r], ack);
      bus_stop();
      check_pairs("R6", {b6[r][2:0], b7[r][4], b7[r][2], b7[r][0]});
    end
    chk("R8", "shortened or split high pulses", glitch[7:0], 8'h00);
  endtask

  initial begin
    #1005;
    rst = 1'b0;
    tick(20);
    t_reset_state();
    t_wrong_address();
    t_block_write();
    t_nack_read();
    t_restart();
    t_toggle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule